// File: doc/BRIEF.md
# Direct-Mapped Tag-Only Cache Evaluator

This block measures how a direct-mapped data cache would behave on a stream of memory references, without holding any data. Each reference is a 32-bit byte address marked as a load or a store. It arrives on a valid/ready input. The block keeps only a tag and a dirty flag per line. It reports whether each reference hits or misses, and whether the line it displaces was dirty. Four running counters sum the references, the misses, the bytes moved to fill lines, and the bytes written toward memory.

The cache geometry is given as log2 parameters: `LOG_SIZE` for total capacity and `LOG_BLOCK` for line size. Supported capacities run from 2^8 to 2^22 bytes. The defaults are kept small so that the line array stays compact. Lines are always allocated on a miss, for loads and stores alike. The `wb_mode` pin chooses how write traffic is counted:
- **Write-back:** a displaced dirty line is charged one full line.
- **Write-through:** each store is charged one 4-byte word, and no line is ever dirty.

`wb_mode` is meant to stay constant between resets.

Back-pressure rules:
- `req_ready` is registered. It is low during reset and for the first cycle after reset, then stays high.
- A reference is taken on any rising edge where `req_valid` and `req_ready` are both high. The source may present a new reference every cycle.
- The result side has no ready signal. `res_valid` is a single-cycle pulse, and the consumer must take it.

Top module: `dm_tag_cache_eval`

## Requirements
- R1: An address is split into three fields. The index is `addr[LOG_SIZE-1:LOG_BLOCK]` and the tag is `addr[31:LOG_SIZE]`; the low `LOG_BLOCK` bits are the byte offset and are ignored. With the defaults (`LOG_SIZE`=10, `LOG_BLOCK`=6) this gives 16 lines. Two addresses in the same line always hit together. Two addresses with the same index but different tags displace each other.
- R2: There is no valid flag. After reset every line holds tag zero and counts as present, so the first reference whose tag field is zero hits.
- R3: A reference accepted at a rising edge raises `res_valid` for exactly the following cycle. In that cycle exactly one of `res_hit` and `res_miss` is high. When `res_valid` is low, `res_hit`, `res_miss` and `res_dirty_evict` are all low.
- R4: Loads and stores follow the same hit/miss rule. On any miss the line takes the new tag, so a store miss allocates the line.
- R5: Each miss adds 2^`LOG_BLOCK` to `cnt_fill_bytes`.
- R6: With `wb_mode`=1, a store marks its line dirty. A miss that displaces a dirty line raises `res_dirty_evict` and adds 2^`LOG_BLOCK` to `cnt_write_bytes`. A miss that displaces a clean line adds nothing to that counter. A line filled by a load starts clean.
- R7: With `wb_mode`=0, every store adds 4 to `cnt_write_bytes`, hit or miss. `res_dirty_evict` stays low and displaced lines add no write traffic.
- R8: `cnt_access` rises by one per accepted reference and `cnt_miss` by one per miss. Both counters are 48 bits wide.
- R9: A synchronous reset clears all four counters, all tags and all dirty flags. It also holds `req_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wb_mode | input | 1 | 1 = write-back counting, 0 = write-through counting |
| req_valid | input | 1 | A reference is offered |
| req_ready | output | 1 | Block accepts a reference this cycle |
| req_addr | input | 32 | Byte address of the reference |
| req_store | input | 1 | 1 = store, 0 = load |
| res_valid | output | 1 | Result pulse, one cycle after acceptance |
| res_hit | output | 1 | Reference hit |
| res_miss | output | 1 | Reference missed |
| res_dirty_evict | output | 1 | The miss displaced a dirty line |
| cnt_access | output | 48 | References accepted since reset |
| cnt_miss | output | 48 | Misses since reset |
| cnt_fill_bytes | output | 48 | Bytes charged for line fills |
| cnt_write_bytes | output | 48 | Bytes charged for writes toward memory |

## Verification
The bench targets the following corner cases, and what a faulty design would do on each:
- **Reset tags.** The very first reference to a zero tag must hit. A design that treated reset lines as empty would report a miss and charge a fill.
- **Offset bits.** Offsets inside one line must hit. A design that decoded the index from the wrong bits would make them miss.
- **Index conflicts.** Two tags that share an index must displace each other. A wrong index would make them miss where they should not, or coexist where they should not.
- **Dirty evictions in write-back mode.** A store followed by a conflicting load must raise the dirty-evict flag and add a full line of write bytes. A load refill must leave the line clean. A design that kept the old dirty flag would charge a second eviction.
- **Write-through charging.** Store hits must be charged 4 bytes. A design that ignored them would under-count.
- **Back-to-back references to one line.** A design that updated tags late would miss where it should hit.
- **Idle cycles and reset.** Idle cycles must produce no result pulse. Reset must clear both the counters and the tags.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef struct packed {
    logic hit;
    logic miss;
    logic dirty_evict;
  } dmc_result_t;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
  parameter int ADDR_W    = 32,
  parameter int LOG_SIZE  = 10,
  parameter int LOG_BLOCK = 6,
  localparam int IDX_W    = LOG_SIZE - LOG_BLOCK,
  localparam int TAG_W    = ADDR_W - LOG_SIZE
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);
  assign idx = addr[LOG_SIZE-1:LOG_BLOCK];
  assign tag = addr[ADDR_W-1:LOG_SIZE];
endmodule

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 22,
  localparam int SETS  = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag,
  input  logic             is_store,
  input  logic             wb_mode,
  output logic             hit,
  output logic             victim_dirty
);
  logic [TAG_W-1:0] tags [SETS];
  logic [SETS-1:0]  dirty;

  assign hit          = (tags[idx] == tag);
  assign victim_dirty = dirty[idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) tags[s] <= '0;
      dirty <= '0;
    end else if (upd_en) begin
      if (!hit) tags[idx] <= tag;
      if (!wb_mode)      dirty[idx] <= 1'b0;
      else if (is_store) dirty[idx] <= 1'b1;
      else if (!hit)     dirty[idx] <= 1'b0;
    end
  end
endmodule

// File: rtl/dmc_traffic_cnt.sv
module dmc_traffic_cnt #(
  parameter int CNT_W     = 48,
  parameter int LOG_BLOCK = 6,
  parameter int WT_BYTES  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_en,
  input  logic             miss,
  input  logic             is_store,
  input  logic             wb_mode,
  input  logic             victim_dirty,
  output logic [CNT_W-1:0] cnt_access,
  output logic [CNT_W-1:0] cnt_miss,
  output logic [CNT_W-1:0] cnt_fill_bytes,
  output logic [CNT_W-1:0] cnt_write_bytes
);
  localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] LINE_INC = ONE << LOG_BLOCK;
  localparam logic [CNT_W-1:0] WORD_INC = CNT_W'(WT_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_access      <= '0;
      cnt_miss        <= '0;
      cnt_fill_bytes  <= '0;
      cnt_write_bytes <= '0;
    end else if (acc_en) begin
      cnt_access <= cnt_access + ONE;
      if (miss) begin
        cnt_miss       <= cnt_miss + ONE;
        cnt_fill_bytes <= cnt_fill_bytes + LINE_INC;
      end
      if (wb_mode) begin
        if (miss && victim_dirty) cnt_write_bytes <= cnt_write_bytes + LINE_INC;
      end else if (is_store) begin
        cnt_write_bytes <= cnt_write_bytes + WORD_INC;
      end
    end
  end
endmodule

// File: rtl/dm_tag_cache_eval.sv
module dm_tag_cache_eval
  import dmc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LOG_SIZE  = 10,
  parameter int LOG_BLOCK = 6,
  parameter int CNT_W     = 48,
  parameter int WT_BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_store,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_miss,
  output logic              res_dirty_evict,
  output logic [CNT_W-1:0]  cnt_access,
  output logic [CNT_W-1:0]  cnt_miss,
  output logic [CNT_W-1:0]  cnt_fill_bytes,
  output logic [CNT_W-1:0]  cnt_write_bytes
);
  localparam int IDX_W = LOG_SIZE - LOG_BLOCK;
  localparam int TAG_W = ADDR_W - LOG_SIZE;

  logic             ready_q;
  logic             accept;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             hit;
  logic             victim_dirty;
  logic             res_v_q;
  dmc_result_t      res_q;

  assign accept    = req_valid && ready_q;
  assign req_ready = ready_q;

  dmc_addr_split #(.ADDR_W(ADDR_W), .LOG_SIZE(LOG_SIZE), .LOG_BLOCK(LOG_BLOCK)) u_split (
    .addr (req_addr),
    .idx  (idx),
    .tag  (tag)
  );

  dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk          (clk),
    .rst          (rst),
    .upd_en       (accept),
    .idx          (idx),
    .tag          (tag),
    .is_store     (req_store),
    .wb_mode      (wb_mode),
    .hit          (hit),
    .victim_dirty (victim_dirty)
  );

  dmc_traffic_cnt #(.CNT_W(CNT_W), .LOG_BLOCK(LOG_BLOCK), .WT_BYTES(WT_BYTES)) u_cnt (
    .clk             (clk),
    .rst             (rst),
    .acc_en          (accept),
    .miss            (!hit),
    .is_store        (req_store),
    .wb_mode         (wb_mode),
    .victim_dirty    (victim_dirty),
    .cnt_access      (cnt_access),
    .cnt_miss        (cnt_miss),
    .cnt_fill_bytes  (cnt_fill_bytes),
    .cnt_write_bytes (cnt_write_bytes)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      res_v_q <= 1'b0;
      res_q   <= '0;
    end else begin
      ready_q           <= 1'b1;
      res_v_q           <= accept;
      res_q.hit         <= accept && hit;
      res_q.miss        <= accept && !hit;
      res_q.dirty_evict <= accept && !hit && wb_mode && victim_dirty;
    end
  end

  assign res_valid       = res_v_q;
  assign res_hit         = res_q.hit;
  assign res_miss        = res_q.miss;
  assign res_dirty_evict = res_q.dirty_evict;
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
  parameter int CNT_W     = 48,
  parameter int LOG_BLOCK = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             wb_mode,
  input logic             req_valid,
  input logic             req_ready,
  input logic             res_valid,
  input logic             res_hit,
  input logic             res_miss,
  input logic             res_dirty_evict,
  input logic [CNT_W-1:0] cnt_access,
  input logic [CNT_W-1:0] cnt_miss,
  input logic [CNT_W-1:0] cnt_fill_bytes
);
  localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] LINE_INC = ONE << LOG_BLOCK;

  // R3: result one cycle after acceptance
  a_r3_latency: assert property (@(posedge clk) disable iff (rst)
    res_valid == $past(req_valid && req_ready));

  // R3: exactly one outcome per result, none when idle
  a_r3_one_outcome: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_hit != res_miss));

  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !(res_hit || res_miss || res_dirty_evict));

  // R6: a dirty eviction only on a miss
  a_r6_evict_on_miss: assert property (@(posedge clk) disable iff (rst)
    res_dirty_evict |-> res_miss);

  // R7: no dirty eviction in write-through mode
  a_r7_wt_no_evict: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !$past(wb_mode)) |-> !res_dirty_evict);

  // R5: each miss adds a line of fill bytes
  a_r5_fill_step: assert property (@(posedge clk) disable iff (rst)
    res_miss |-> (cnt_fill_bytes == $past(cnt_fill_bytes) + LINE_INC));

  // R8: access and miss counters step by one
  a_r8_access_step: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (cnt_access == $past(cnt_access) + ONE));

  a_r8_miss_step: assert property (@(posedge clk) disable iff (rst)
    res_miss |-> (cnt_miss == $past(cnt_miss) + ONE));

  // R9: ready held low by reset
  a_r9_ready_low: assert property (@(posedge clk)
    rst |=> !req_ready);
endmodule

bind dm_tag_cache_eval dmc_checker #(.CNT_W(CNT_W), .LOG_BLOCK(LOG_BLOCK)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .wb_mode         (wb_mode),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .res_valid       (res_valid),
  .res_hit         (res_hit),
  .res_miss        (res_miss),
  .res_dirty_evict (res_dirty_evict),
  .cnt_access      (cnt_access),
  .cnt_miss        (cnt_miss),
  .cnt_fill_bytes  (cnt_fill_bytes)
);

// File: tb/dm_tag_cache_eval_tb_top.sv
module dm_tag_cache_eval_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LS = 10;
  localparam int LB = 6;
  localparam int NSETS = 1 << (LS - LB);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wb_mode = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_store = 1'b0;
  logic        res_valid, res_hit, res_miss, res_dirty_evict;
  logic [47:0] cnt_access, cnt_miss, cnt_fill_bytes, cnt_write_bytes;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [2:0]  exp_q[$];
  logic [31:0] m_tag [NSETS];
  logic        m_dirty [NSETS];
  longint      m_acc, m_miss, m_fill, m_wr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dm_tag_cache_eval #(.LOG_SIZE(LS), .LOG_BLOCK(LB)) dut_i (
    .clk(clk), .rst(rst), .wb_mode(wb_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_store(req_store),
    .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss), .res_dirty_evict(res_dirty_evict),
    .cnt_access(cnt_access), .cnt_miss(cnt_miss),
    .cnt_fill_bytes(cnt_fill_bytes), .cnt_write_bytes(cnt_write_bytes)
  );

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < NSETS; s++) begin
      m_tag[s] = '0;
      m_dirty[s] = 1'b0;
    end
    m_acc = 0; m_miss = 0; m_fill = 0; m_wr = 0;
  endtask

  // driver: computes the expected outcome, queues it, presents the reference
  task automatic send(input logic [31:0] a, input logic st);
    int    ix;
    logic  h, ev;
    ix = int'((a >> LB) % NSETS);
    h  = (m_tag[ix] == (a >> LS));
    ev = !h && wb_mode && m_dirty[ix];
    m_acc++;
    if (!h) begin
      m_miss++;
      m_fill += (1 << LB);
      if (ev) m_wr += (1 << LB);
      m_tag[ix]   = a >> LS;
      m_dirty[ix] = 1'b0;
    end
    if (st) begin
      if (wb_mode) m_dirty[ix] = 1'b1;
      else m_wr += 4;
    end
    exp_q.push_back({h, !h, ev});
    req_valid = 1'b1;
    req_addr  = a;
    req_store = st;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_counters(input string tagname);
    check(cnt_access == 48'(m_acc), {"R8 access ", tagname}, cnt_access, m_acc);
    check(cnt_miss == 48'(m_miss), {"R8 miss ", tagname}, cnt_miss, m_miss);
    check(cnt_fill_bytes == 48'(m_fill), {"R5 fill ", tagname}, cnt_fill_bytes, m_fill);
    check(cnt_write_bytes == 48'(m_wr), {"R6 R7 write ", tagname}, cnt_write_bytes, m_wr);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(req_ready == 1'b0, "R9 ready low in reset", req_ready, 0);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    check(req_ready == 1'b1, "R9 ready after reset", req_ready, 1);
    check_counters("R9 after reset");
  endtask

  // monitor: pops expected outcomes as results appear
  always @(negedge clk) begin
    if (!rst) begin
      if (res_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 result without request", 1, 0);
        end else begin
          logic [2:0] e;
          e = exp_q.pop_front();
          check({res_hit, res_miss, res_dirty_evict} == e, "R1 R2 R4 R6 R7 outcome",
                {res_hit, res_miss, res_dirty_evict}, e);
        end
      end else if (res_hit || res_miss || res_dirty_evict) begin
        check(1'b0, "R3 flags while idle", {res_hit, res_miss, res_dirty_evict}, 0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    model_reset();
    @(negedge clk);
    check(req_ready == 1'b0, "R9 ready low at start", req_ready, 0);
    wb_mode = 1'b1;
    do_reset();

    // write-back phase
    send(32'h0000_0000, 1'b0);  // R2: zero tag hits after reset
    send(32'h0000_0004, 1'b0);  // R1: same line, other offset
    send(32'h0000_0010, 1'b1);  // R6: store hit marks dirty
    send(32'h0000_0400, 1'b0);  // R6: conflict evicts dirty line
    send(32'h0000_0000, 1'b0);  // R6: clean eviction
    send(32'h0000_1440, 1'b1);  // R4: store miss allocates
    send(32'h0000_1450, 1'b0);  // R4: then hits
    send(32'h0000_0040, 1'b0);  // R6: dirty eviction of stored line
    @(negedge clk);
    check_counters("directed wb");
    for (int i = 0; i < 48; i++) send(32'(i * 320 + (i % 3) * 4), i[0]);
    for (int i = 0; i < 40; i++) send(32'((i % 5) * 1024 + 64 * (i % 4)), (i % 3) == 0);
    repeat (3) @(negedge clk);  // R3: idle cycles, no result expected
    check(exp_q.size() == 0, "R3 all results seen", exp_q.size(), 0);
    check_counters("sweep wb");

    // reset clears tags and counters
    do_reset();
    send(32'h0000_0400, 1'b0);  // R9: tag cleared, tag 1 misses
    send(32'h0000_0000, 1'b0);
    @(negedge clk);
    check_counters("R9 post-reset access");

    // write-through phase
    wb_mode = 1'b0;
    do_reset();
    send(32'h0000_0000, 1'b1);  // R7: store hit charged
    send(32'h0000_0400, 1'b1);  // R7: store miss charged, no eviction
    send(32'h0000_0800, 1'b0);  // R7: no dirty eviction
    @(negedge clk);
    check_counters("directed wt");
    for (int i = 0; i < 60; i++) send(32'(i * 704 + (i % 7) * 8), (i % 2) == 1);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R3 all results seen wt", exp_q.size(), 0);
    check_counters("sweep wt");
    summary();
  end
endmodule